// File: doc/BRIEF.md
# Multi-Mode Logarithmic Shifter

This block shifts a WIDTH-bit data word by a binary amount from 0 to WIDTH-1, toward the most significant end (left) or the least significant end (right). A two-bit type code selects how vacated positions are filled: with zeros (logical), with copies of the sign bit (arithmetic, on right shifts), or with the bits pushed out of the other end (circular). It is meant for datapaths such as normalisers, multipliers and general-purpose execution units that need one shared shifter for all shift flavours.

The datapath is a cascade of log2(WIDTH) stages. The stage of rank k moves the word by 2^k places or leaves it alone, driven by amount bit k only. Every stage chooses its own fill bit from its own input, so one chain serves all types and both directions. A parameter adds an optional output register with an asynchronous active-low reset; without it the block is purely combinational. WIDTH must be a power of two of at least 2 and is checked at elaboration; 8 is the default and 32 is a supported configuration.

Top module: `lsh_unit`

## Requirements
- R1: With type code 2'b00 and `dir_left`=0, the result is the data moved right by `amt` places with the top `amt` positions set to 0.
- R2: With `dir_left`=1 and type code 2'b00 or 2'b01, the result is the data moved left by `amt` places with the bottom `amt` positions set to 0 (arithmetic left equals logical left).
- R3: With type code 2'b01 and `dir_left`=0, the result is the data moved right by `amt` places with the top `amt` positions copied from input bit WIDTH-1 (on 4 bits, amount 2 gives {A3,A3,A3,A2}).
- R4: With type code 2'b10 and `dir_left`=0, result bit i equals input bit (i+amt) mod WIDTH; no bit is lost.
- R5: With type code 2'b10 and `dir_left`=1, result bit i equals input bit (i-amt) mod WIDTH; no bit is lost.
- R6: An amount of 0 returns the input unchanged for every type code and direction.
- R7: Type code 2'b11 is reserved and gives exactly the logical result of R1/R2.
- R8: Amounts combining several set bits (any value up to WIDTH-1) produce the full shift, since each amount bit k independently adds 2^k places.
- R9: With `OUT_REG`=1 the result appears on `dout` one clock edge after the inputs are presented, and `dout` is 0 while `rst_n` is low; with `OUT_REG`=0, `dout` follows the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| din | input | WIDTH | Word to be shifted |
| amt | input | AMT_W | Shift distance, unsigned, 0 to WIDTH-1 |
| dir_left | input | 1 | 1 = toward MSB, 0 = toward LSB |
| kind | input | 2 | 00 logical, 01 arithmetic, 10 circular, 11 reserved (logical) |
| dout | output | WIDTH | Shifted word |

## Verification
The embedded properties check on every cycle the invariants that hold whatever the data: a zero amount is an identity, circular shifts keep the population count, an arithmetic right shift keeps the sign bit, non-circular shifts clear the vacated end bit, and the registered variant presents last cycle's result. Only the bench's scenarios show the exact bit placement for each amount, that combined amount bits compose into the right total distance, that the reserved code matches the logical result, and the reset value of the register; it sweeps every amount, direction and type code over random words and all-ones, alternating and single-bit patterns, at widths 8 and 32.

// File: rtl/lsh_pkg.sv
package lsh_pkg;

   typedef enum logic [1:0] {
      SK_LOGIC  = 2'b00,
      SK_ARITH  = 2'b01,
      SK_ROTATE = 2'b10,
      SK_RSVD   = 2'b11
   } shift_kind_e;

   // Fill selection shared by every stage of the chain
   typedef struct packed {
      logic wrap;   // re-insert bits leaving the opposite end
      logic sign;   // replicate MSB on right shifts
   } fill_sel_t;

endpackage

// File: rtl/lsh_ctl.sv
module lsh_ctl
   import lsh_pkg::*;
(
   input  logic [1:0] kind_code,
   output fill_sel_t  sel
);
   always_comb begin
      sel = '0;
      case (shift_kind_e'(kind_code))
         SK_ARITH:  sel.sign = 1'b1;
         SK_ROTATE: sel.wrap = 1'b1;
         default:   sel = '0;   // logical and reserved code
      endcase
   end
endmodule

// File: rtl/lsh_stage.sv
module lsh_stage #(
   parameter int WIDTH = 8,
   parameter int STEP  = 1
) (
   input  logic [WIDTH-1:0] d_in,
   input  logic             en,
   input  logic             left,
   input  logic             wrap,
   input  logic             sign,
   output logic [WIDTH-1:0] d_out
);
   logic [WIDTH-1:0] to_right;
   logic [WIDTH-1:0] to_left;
   logic             hi_fill;

   if (STEP < 1 || STEP >= WIDTH) begin : g_bad_step
      $error("lsh_stage: STEP must lie in 1..WIDTH-1");
   end

   assign hi_fill = sign & d_in[WIDTH-1];

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i + STEP < WIDTH) begin : g_r_body
         assign to_right[i] = d_in[i+STEP];
      end else begin : g_r_edge
         assign to_right[i] = wrap ? d_in[i+STEP-WIDTH] : hi_fill;
      end
      if (i >= STEP) begin : g_l_body
         assign to_left[i] = d_in[i-STEP];
      end else begin : g_l_edge
         assign to_left[i] = wrap & d_in[i+WIDTH-STEP];
      end
   end

   always_comb begin
      if (!en)       d_out = d_in;
      else if (left) d_out = to_left;
      else           d_out = to_right;
   end
endmodule

// File: rtl/lsh_unit.sv
module lsh_unit
   import lsh_pkg::*;
#(
   parameter int WIDTH   = 8,
   parameter int AMT_W   = $clog2(WIDTH),
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   input  logic [AMT_W-1:0] amt,
   input  logic             dir_left,
   input  logic [1:0]       kind,
   output logic [WIDTH-1:0] dout
);
   localparam int STAGES = $clog2(WIDTH);

   if (WIDTH < 2 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
      $error("lsh_unit: WIDTH must be a power of two, at least 2");
   end
   if (AMT_W != STAGES) begin : g_bad_amt
      $error("lsh_unit: AMT_W must equal log2(WIDTH)");
   end

   fill_sel_t        sel;
   logic [WIDTH-1:0] chain [0:STAGES];
   logic [WIDTH-1:0] shifted;

   lsh_ctl u_ctl (
      .kind_code (kind),
      .sel       (sel)
   );

   assign chain[0] = din;

   // Stage k moves by 2^k under amount bit k alone
   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      lsh_stage #(
         .WIDTH (WIDTH),
         .STEP  (1 << k)
      ) u_stage (
         .d_in  (chain[k]),
         .en    (amt[k]),
         .left  (dir_left),
         .wrap  (sel.wrap),
         .sign  (sel.sign),
         .d_out (chain[k+1])
      );
   end

   assign shifted = chain[STAGES];

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) dout <= '0;
         else        dout <= shifted;
      end

      // R9: registered output carries the previous cycle's result
      a_r9_reg_latency: assert property (@(posedge clk) disable iff (!rst_n)
         rst_n |=> dout == $past(shifted));
   end else begin : g_comb
      assign dout = shifted;
   end

   // R6: zero distance is an identity
   a_r6_zero_identity: assert property (@(posedge clk) disable iff (!rst_n)
      (amt == '0) |-> (shifted == din));

   // R4 and R5: circular shifts keep every bit
   a_r4_rot_keeps_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == 2'b10) |-> ($countones(shifted) == $countones(din)));

   // R3: arithmetic right keeps the sign bit
   a_r3_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == 2'b01 && !dir_left) |-> (shifted[WIDTH-1] == din[WIDTH-1]));

   // R1 and R7: non-zero logical right clears the MSB
   a_r1_msb_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (kind[0] == kind[1] && !dir_left && amt != '0) |-> !shifted[WIDTH-1]);

   // R2: non-zero non-circular left clears the LSB
   a_r2_lsb_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (kind != 2'b10 && dir_left && amt != '0) |-> !shifted[0]);
endmodule

// File: tb/lsh_unit_test.sv
module lsh_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  din8;
   logic [2:0]  amt8;
   logic [31:0] din32;
   logic [4:0]  amt32;
   logic        dir_left;
   logic [1:0]  kind;
   logic [7:0]  dout8;
   logic [31:0] dout32;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   lsh_unit #(.WIDTH(8)) uut (
      .clk(clk), .rst_n(rst_n), .din(din8), .amt(amt8),
      .dir_left(dir_left), .kind(kind), .dout(dout8));

   lsh_unit #(.WIDTH(32), .OUT_REG(1'b1)) uut32 (
      .clk(clk), .rst_n(rst_n), .din(din32), .amt(amt32),
      .dir_left(dir_left), .kind(kind), .dout(dout32));

   // Per-bit reference: each output bit picks its source directly
   function automatic logic [31:0] ref_shift(int w, logic [31:0] d, int a,
                                             bit left, logic [1:0] k);
      logic [31:0] r = '0;
      for (int i = 0; i < w; i++) begin
         int src = left ? i - a : i + a;
         if (src >= 0 && src < w)      r[i] = d[src];
         else if (k == 2'b10)          r[i] = left ? d[src + w] : d[src - w];
         else if (k == 2'b01 && !left) r[i] = d[w-1];
         else                          r[i] = 1'b0;
      end
      return r;
   endfunction

   function automatic string tag(int a, bit left, logic [1:0] k);
      if (a == 0)               return "R6";
      if (k == 2'b11)           return "R7";
      if ($countones(a) > 1)    return "R8";
      if (k == 2'b10)           return left ? "R5" : "R4";
      if (left)                 return "R2";
      if (k == 2'b01)           return "R3";
      return "R1";
   endfunction

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s: got %h expected %h (amt8=%0d amt32=%0d left=%0b kind=%0d)",
                  req, got, exp, amt8, amt32, dir_left, kind);
      end
   endtask

   // Drive at negedge, sample 1 time unit after the next posedge
   task automatic apply(logic [7:0] d8, int a8, logic [31:0] d32, int a32,
                        bit left, logic [1:0] k);
      @(negedge clk);
      din8 = d8; amt8 = 3'(a8); din32 = d32; amt32 = 5'(a32);
      dir_left = left; kind = k;
      @(posedge clk);
      #1;
      check(tag(a8, left, k), {24'h0, dout8}, ref_shift(8, {24'h0, d8}, a8, left, k));
      check({"R9/", tag(a32, left, k)}, dout32, ref_shift(32, d32, a32, left, k));
   endtask

   initial begin
      logic [7:0]  pat8  [0:7];
      logic [31:0] pat32 [0:7];
      void'($urandom(32'd1947));
      din8 = '0; amt8 = '0; din32 = '0; amt32 = '0; dir_left = 1'b0; kind = 2'b00;
      pat8  = '{8'h00, 8'hFF, 8'hAA, 8'h55, 8'h01, 8'h80, 8'h96, 8'h3C};
      pat32 = '{32'hFFFF_FFFF, 32'hAAAA_AAAA, 32'h5555_5555, 32'h0000_0001,
                32'h8000_0000, 32'h0001_0000, 32'hDEAD_BEEF, 32'h0F0F_1234};

      // R9: register holds zero in reset
      din32 = 32'hFFFF_FFFF;
      repeat (3) @(posedge clk);
      #1 check("R9 reset", dout32, 32'h0);
      @(negedge clk) rst_n = 1'b1;

      // Directed patterns: every amount, direction and type code (R1..R8)
      for (int p = 0; p < 8; p++)
         for (int k = 0; k < 4; k++)
            for (int l = 0; l < 2; l++)
               for (int a = 0; a < 32; a++)
                  apply(pat8[p], a % 8, pat32[p], a, l[0], 2'(k));

      // Random data over the full control space
      for (int n = 0; n < 12; n++)
         for (int k = 0; k < 4; k++)
            for (int l = 0; l < 2; l++)
               for (int a = 0; a < 32; a++)
                  apply(8'($urandom), a % 8, $urandom, a, l[0], 2'(k));

      // 4-bit arithmetic example mapped to the top nibble: 0xB0 >>> 2 = 0xEC (R3)
      apply(8'hB0, 2, 32'h0, 0, 1'b0, 2'b01);
      check("R3 nibble", {24'h0, dout8}, 32'hEC);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         miscompares++;
         vectors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule